// File: doc/BRIEF.md
# Sign-Extending Right Shift with Rotate Capture

This block is the execution datapath of a 32-bit right-shift instruction that preserves the sign. A source word is shifted right arithmetically by a count taken from the low bits of a shift operand, and the same word rotated right by that count is produced for an extension register. A carry flag reports whether a negative word lost any one bits during the shift. When the instruction asks for it, a four-bit condition field is also produced from the signed result.

Operands arrive with a valid strobe. Every output is registered and appears one clock later together with an output valid. Register-file access, decode and other shift forms belong to the surrounding pipeline.

Top module: `srx_unit`

## Requirements
- R1: The shift count n is bits [4:0] of `shift_opnd`; bits [31:5] have no effect on any output.
- R2: `result` is `src_word` shifted right by n with bit 31 copied into the n vacated upper positions. When n is 0, `result` equals `src_word`.
- R3: `rot_word` is `src_word` rotated right by n. Bit i of `rot_word` is source bit (i+n) mod 32.
- R4: `carry_out` is 1 only when `src_word[31]` is 1 and at least one of the source bits [n-1:0] is 1. It is 0 when n is 0, when the source is non-negative, and when only zero bits are shifted out.
- R5: `cond_wr` is 1 in the cycle after an accepted operand whose `record_en` was 1. It is 0 in every other cycle.
- R6: When `cond_wr` is 1, `cond_field` holds {LT, GT, EQ, SO} in bits [3:0]. LT means the result is negative, GT means positive and nonzero, EQ means zero, and SO is a copy of the `summary_ovf` value that came with the operand.
- R7: `out_valid` is 1 exactly in the cycle after `in_valid` was 1. While reset is active, `out_valid`, `carry_out`, `cond_wr` and `cond_field` are 0.
- R8: In a cycle after `in_valid` was 0, `result`, `rot_word` and `carry_out` keep their previous values, whatever is on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src_word | input | 32 | Word to be shifted |
| shift_opnd | input | 32 | Shift operand; the low five bits give the count |
| record_en | input | 1 | Request a condition-field update |
| summary_ovf | input | 1 | Current sticky overflow bit |
| out_valid | output | 1 | Registered outputs are new |
| result | output | 32 | Arithmetic shift result |
| rot_word | output | 32 | Rotated word for the extension register |
| carry_out | output | 1 | Carry flag |
| cond_wr | output | 1 | Condition-field write strobe |
| cond_field | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench uses the default widths: a 32-bit data word and a 32-bit shift operand. With these widths every count from 0 to 31 can be driven, and the upper operand bits can be set to show that they have no effect. The vectors include negative and positive sources at n = 0 and n = 31, words that lose only zero bits or only one bits, a zero result, and a long pseudo-random run. Idle cycles with changing inputs check that the outputs hold their values.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/srx_shifter.sv
`timescale 1ns/1ps
module srx_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] shifted,
  output logic [DATA_W-1:0] rotated,
  output logic              lost_ones
);
  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   keep_mask;

  always_comb begin
    doubled   = {src, src} >> cnt;
    rotated   = doubled[DATA_W-1:0];
    shifted   = DATA_W'($signed(src) >>> cnt);
    keep_mask = {DATA_W{1'b1}} >> cnt;
    // rotated bits outside the keep mask are the bits that were shifted out
    lost_ones = |(rotated & ~keep_mask);
  end
endmodule

// File: rtl/srx_flags.sv
`timescale 1ns/1ps
module srx_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] shifted,
  input  logic              src_sign,
  input  logic              lost_ones,
  input  logic              so_in,
  output logic              carry,
  output srx_pkg::cond_t    cond
);
  always_comb begin
    carry   = src_sign & lost_ones;
    cond.lt = shifted[DATA_W-1];
    cond.eq = (shifted == '0);
    cond.gt = ~shifted[DATA_W-1] & (shifted != '0);
    cond.so = so_in;
  end
endmodule

// File: rtl/srx_unit.sv
`timescale 1ns/1ps
module srx_unit #(
  parameter int DATA_W = 32,
  parameter int OPB_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_word,
  input  logic [OPB_W-1:0]  shift_opnd,
  input  logic              record_en,
  input  logic              summary_ovf,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] rot_word,
  output logic              carry_out,
  output logic              cond_wr,
  output logic [3:0]        cond_field
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt;
  logic              unused_opnd_hi;
  logic [DATA_W-1:0] shifted_c, rotated_c;
  logic              lost_c, carry_c;
  srx_pkg::cond_t    cond_c;

  assign cnt            = shift_opnd[CNT_W-1:0];
  assign unused_opnd_hi = ^shift_opnd[OPB_W-1:CNT_W];

  srx_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .src       (src_word),
    .cnt       (cnt),
    .shifted   (shifted_c),
    .rotated   (rotated_c),
    .lost_ones (lost_c)
  );

  srx_flags #(.DATA_W(DATA_W)) u_flags (
    .shifted   (shifted_c),
    .src_sign  (src_word[DATA_W-1]),
    .lost_ones (lost_c),
    .so_in     (summary_ovf),
    .carry     (carry_c),
    .cond      (cond_c)
  );

  // next state
  logic           valid_d, cwr_d, carry_d;
  srx_pkg::cond_t cond_d, cond_q;
  logic           rec_take;

  always_comb begin
    rec_take = in_valid & record_en;
    valid_d  = in_valid;
    cwr_d    = rec_take;
    carry_d  = in_valid ? carry_c : carry_out;
    cond_d   = rec_take ? cond_c : cond_q;
  end

  // control and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cond_wr   <= 1'b0;
      carry_out <= 1'b0;
      cond_q    <= '0;
    end else begin
      out_valid <= valid_d;
      cond_wr   <= cwr_d;
      carry_out <= carry_d;
      cond_q    <= cond_d;
    end
  end

  // data registers, enabled by the operand strobe
  always_ff @(posedge clk) begin
    if (in_valid) begin
      result   <= shifted_c;
      rot_word <= rotated_c;
    end
  end

  assign cond_field = cond_q;
endmodule

// File: rtl/srx_check.sv
`timescale 1ns/1ps
module srx_check #(
  parameter int DATA_W = 32,
  parameter int OPB_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] src_word,
  input logic [OPB_W-1:0]  shift_opnd,
  input logic              record_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] rot_word,
  input logic              carry_out,
  input logic              cond_wr,
  input logic [3:0]        cond_field
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (in_valid) seen <= 1'b1;
  end

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_no_carry_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !src_word[DATA_W-1]) |=> !carry_out);
  a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_opnd[4:0] == 5'd0) |=> (!carry_out && result == $past(src_word)));
  a_r3_zero_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_opnd[4:0] == 5'd0) |=> (rot_word == $past(src_word)));
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && record_en) |=> cond_wr);
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && record_en) |=> !cond_wr);
  a_r6_one_sign_class: assert property (@(posedge clk) disable iff (!rst_n)
    cond_wr |-> $countones(cond_field[3:1]) == 1);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !in_valid) |=> ($stable(result) && $stable(rot_word) && $stable(carry_out)));
endmodule

bind srx_unit srx_check #(.DATA_W(DATA_W), .OPB_W(OPB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .src_word   (src_word),
  .shift_opnd (shift_opnd),
  .record_en  (record_en),
  .out_valid  (out_valid),
  .result     (result),
  .rot_word   (rot_word),
  .carry_out  (carry_out),
  .cond_wr    (cond_wr),
  .cond_field (cond_field)
);

// File: tb/sim_srx_unit.sv
`timescale 1ns/1ps
module sim_srx_unit;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, record_en, summary_ovf;
  logic [31:0] src_word, shift_opnd;
  logic        out_valid, carry_out, cond_wr;
  logic [31:0] result, rot_word;
  logic [3:0]  cond_field;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] last_res, last_rot;
  logic        last_cy;

  always #10 clk = ~clk;

  srx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
    .shift_opnd(shift_opnd), .record_en(record_en), .summary_ovf(summary_ovf),
    .out_valid(out_valid), .result(result), .rot_word(rot_word),
    .carry_out(carry_out), .cond_wr(cond_wr), .cond_field(cond_field)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, bit by bit
  function automatic logic [31:0] m_shift(logic [31:0] s, int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? s[i + n] : s[31];
    return r;
  endfunction
  function automatic logic [31:0] m_rot(logic [31:0] s, int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = s[(i + n) % 32];
    return r;
  endfunction
  function automatic logic m_carry(logic [31:0] s, int n);
    logic any = 1'b0;
    for (int i = 0; i < n; i++) any |= s[i];
    return s[31] & any;
  endfunction
  function automatic logic [3:0] m_cond(logic [31:0] r, logic so);
    int signed v = $signed(r);
    return {v < 0, v > 0, v == 0, so};
  endfunction

  task automatic apply(input logic [31:0] s, input logic [31:0] b,
                       input logic rec, input logic so, input string tag);
    int n = int'(b & 32'd31);
    logic [31:0] er = m_shift(s, n);
    logic [31:0] eo = m_rot(s, n);
    logic        ec = m_carry(s, n);
    src_word = s; shift_opnd = b; record_en = rec; summary_ovf = so; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R7 out_valid ", tag}, {31'd0, out_valid}, 32'd1);
    chk({"R2 result ", tag}, result, er);
    chk({"R3 rot_word ", tag}, rot_word, eo);
    chk({"R4 carry ", tag}, {31'd0, carry_out}, {31'd0, ec});
    chk({"R5 cond_wr ", tag}, {31'd0, cond_wr}, {31'd0, rec});
    if (rec) chk({"R6 cond_field ", tag}, {28'd0, cond_field}, {28'd0, m_cond(er, so)});
    last_res = er; last_rot = eo; last_cy = ec;
  endtask

  task automatic idle(input logic [31:0] s, input logic [31:0] b);
    src_word = s; shift_opnd = b; record_en = 1'b1; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 out_valid idle", {31'd0, out_valid}, 32'd0);
    chk("R5 cond_wr idle", {31'd0, cond_wr}, 32'd0);
    chk("R8 result hold", result, last_res);
    chk("R8 rot_word hold", rot_word, last_rot);
    chk("R8 carry hold", {31'd0, carry_out}, {31'd0, last_cy});
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; record_en = 1'b1; summary_ovf = 1'b1;
    src_word = 32'hFFFF_FFFF; shift_opnd = 32'd4;
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R7 reset carry", {31'd0, carry_out}, 32'd0);
    chk("R7 reset cond_wr", {31'd0, cond_wr}, 32'd0);
    chk("R7 reset cond_field", {28'd0, cond_field}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    apply(32'h8000_0000, 32'd31, 1'b1, 1'b0, "neg n31 zeros out");
    apply(32'hFFFF_FFFF, 32'd31, 1'b1, 1'b1, "neg n31 ones out");
    apply(32'h8000_0001, 32'd1,  1'b0, 1'b0, "neg n1 one out");
    apply(32'hF000_00F0, 32'd4,  1'b1, 1'b0, "neg zeros only out");
    apply(32'h7FFF_FFFF, 32'd5,  1'b1, 1'b0, "pos ones out no carry");
    apply(32'h7FFF_FFFF, 32'd31, 1'b1, 1'b1, "pos n31 zero result");
    apply(32'h8765_4321, 32'd0,  1'b1, 1'b0, "neg n0");
    apply(32'h1234_5678, 32'd0,  1'b1, 1'b1, "pos n0");
    apply(32'h8000_0007, 32'hFFFF_FFE3, 1'b1, 1'b0, "R1 upper bits set n3");
    apply(32'h8000_0007, 32'h0000_0020, 1'b1, 1'b0, "R1 count 32 acts as 0");
    idle(32'hDEAD_BEEF, 32'd7);
    idle(32'h0000_0001, 32'd1);
    apply(32'h0000_0000, 32'd9,  1'b1, 1'b1, "zero source");
    apply(32'hC000_0000, 32'd2,  1'b0, 1'b1, "no record");
    idle(32'hFFFF_FFFF, 32'd30);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      apply(a, b, b[7], b[9], "random");
      if (b[10]) idle(~a, ~b);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule